// File: doc/BRIEF.md
# Snapshot-Latched Cycle Counter

This block counts clock cycles from the most recent reset, so that software can read a timestamp at a fixed bus location and measure how far apart two events are. A free-running counter advances on every clock, or on every N-th clock when the prescaler is built in. A bus read never returns the live count. The first clock edge that samples the read strobe copies the count into a snapshot register. The bus then shows that frozen value for as long as the strobe stays high, so a count that changes during the access cannot give a torn result.

The count is wider than the data bus, so it is read as two words. A high-word read captures the whole count. The next low-word read returns the low half of that same capture and does not take a new one, so the two halves always belong together. A low-word read with no high half waiting takes a fresh capture of its own. A small state machine handles the sequence. Its states are `ST_IDLE`, `ST_HOLD_HI` (a high-word access is in progress), `ST_PEND_LO` (a high half has been read and its low half is waiting) and `ST_HOLD_LO` (a low-word access is in progress).

The state machine has these transitions:
- From `ST_IDLE`, a strobe with `word_hi` high captures and goes to `ST_HOLD_HI`. A strobe with `word_hi` low captures and goes to `ST_HOLD_LO`.
- `ST_HOLD_HI` goes to `ST_PEND_LO` when the strobe drops.
- From `ST_PEND_LO`, a low-word strobe goes to `ST_HOLD_LO` without capturing. A high-word strobe captures again and goes to `ST_HOLD_HI`.
- `ST_HOLD_LO` goes to `ST_IDLE` when the strobe drops.
- Reset forces `ST_IDLE`.

Top module: `cycle_stamp_counter`

## Requirements
- R1: While `rst_n` is low, the count, the snapshot and the state are cleared, and `rd_oe` and `rd_data` read 0. A read after reset returns the number of counter steps taken since reset was released.
- R2: With `PRESCALE` = 1, the count advances by exactly one on every clock edge after reset.
- R3: The count is `CNT_W` bits wide (24 by default). A high-word read returns count bits [CNT_W-1:DATA_W] in the low bits of `rd_data`, and the upper bits of `rd_data` are zero. A low-word read returns count bits [DATA_W-1:0].
- R4: With `PRESCALE` = P > 1, the count advances by one only on every P-th clock, which is the terminal count of the prescaler. On the other clocks it holds its value.
- R5: While the strobe stays high, `rd_data` does not change, even though the counter keeps running.
- R6: A high-word read captures the full count. The next low-word read returns the low bits of that same capture, however long the gap between the two reads. A second high-word read in a row captures again.
- R7: A low-word read in `ST_IDLE` takes a fresh capture of the count at the edge where the strobe is first sampled.
- R8: When no access is in progress, `rd_oe` is 0 and `rd_data` is all zeros.
- R9: The count wraps from its maximum value to 0 without saturating. The wrap does not change a capture that is already held or pending.
- R10: `rd_oe` rises one clock after the edge where the strobe is first sampled high. It falls one clock after the edge where the strobe is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each edge is one cycle to be counted |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_sel | input | 1 | Read strobe for the counter address, from the bus decode, active high |
| word_hi | input | 1 | Word select sampled with the strobe: 1 selects the high word, 0 the low word |
| rd_data | output | DATA_W (16) | Snapshot word, all zeros outside an access |
| rd_oe | output | 1 | High while a snapshot word is driven |

## Verification
The bench builds two instances. The first, `dut`, uses the default 24-bit count, 16-bit bus and no divider. It runs long enough for the count to cross 65536, so the high word carries a nonzero value. The second, `dut_div`, uses a 6-bit count, a 4-bit bus and a divide-by-3 prescaler. This makes a wrap reachable within a few hundred cycles, so the bench can hold a capture through a wrap and leave one pending across it. It also makes the spacing of the prescaler steps visible.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

    // Read sequencing states of the snapshot port.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD_HI = 2'd1,
        ST_PEND_LO = 2'd2,
        ST_HOLD_LO = 2'd3
    } snap_state_t;

endpackage

// File: rtl/stamp_prescaler.sv
module stamp_prescaler #(
    parameter int PRESCALE = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(PRESCALE - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == LAST);

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (PRESCALE > 1)) |=> !tick);

endmodule

// File: rtl/stamp_counter.sv
module stamp_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + CNT_W'(1)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

endmodule

// File: rtl/stamp_snapshot.sv
module stamp_snapshot
    import stamp_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel,
    input  logic              word_hi,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);
    snap_state_t      state_q, state_d;
    logic             capture;
    logic [CNT_W-1:0] snap_q;

    // Next state and capture decision.
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_sel) begin
                    capture = 1'b1;
                    state_d = word_hi ? ST_HOLD_HI : ST_HOLD_LO;
                end
            end
            ST_HOLD_HI: begin
                if (!rd_sel) state_d = ST_PEND_LO;
            end
            ST_PEND_LO: begin
                if (rd_sel) begin
                    capture = word_hi;
                    state_d = word_hi ? ST_HOLD_HI : ST_HOLD_LO;
                end
            end
            ST_HOLD_LO: begin
                if (!rd_sel) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Snapshot register, loaded only by the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (capture) snap_q <= count;
    end

    // Outputs.
    always_comb begin
        rd_data = '0;
        rd_oe   = 1'b0;
        unique case (state_q)
            ST_HOLD_HI: begin
                rd_data = DATA_W'(snap_q >> DATA_W);
                rd_oe   = 1'b1;
            end
            ST_HOLD_LO: begin
                rd_data = snap_q[DATA_W-1:0];
                rd_oe   = 1'b1;
            end
            default: begin
                rd_data = '0;
                rd_oe   = 1'b0;
            end
        endcase
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && rd_sel) |=> $stable(rd_data));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> (rd_data == '0));

    // R10
    oe_onset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_oe) |-> $past(rd_sel));

    // R6
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND_LO && rd_sel && !word_hi) |=>
            ($stable(snap_q) && rd_data == snap_q[DATA_W-1:0]));

endmodule

// File: rtl/cycle_stamp_counter.sv
module cycle_stamp_counter #(
    parameter int CNT_W    = 24,
    parameter int DATA_W   = 16,
    parameter int PRESCALE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel,
    input  logic              word_hi,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);
    logic             tick;
    logic [CNT_W-1:0] count;

    stamp_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    stamp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (count)
    );

    stamp_snapshot #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (rd_sel),
        .word_hi (word_hi),
        .count   (count),
        .rd_data (rd_data),
        .rd_oe   (rd_oe)
    );

endmodule

// File: tb/tb_cycle_stamp_counter.sv
module tb_cycle_stamp_counter;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        rd_sel = 1'b0, word_hi = 1'b0;
    logic [15:0] rd_data;
    logic        rd_oe;
    logic        rs2 = 1'b0, wh2 = 1'b0;
    logic [3:0]  d2;
    logic        oe2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    cycle_stamp_counter dut (
        .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .word_hi(word_hi),
        .rd_data(rd_data), .rd_oe(rd_oe));

    cycle_stamp_counter #(.CNT_W(6), .DATA_W(4), .PRESCALE(3)) dut_div (
        .clk(clk), .rst_n(rst_n), .rd_sel(rs2), .word_hi(wh2),
        .rd_data(d2), .rd_oe(oe2));

    // Expected counts, built from R1, R2 and R4.
    logic [23:0] mcnt;
    logic [5:0]  mcnt2;
    int          mdiv2;
    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt <= '0; mcnt2 <= '0; mdiv2 <= 0;
        end else begin
            mcnt <= mcnt + 24'd1;
            if (mdiv2 == 2) begin
                mdiv2 <= 0;
                mcnt2 <= mcnt2 + 6'd1;
            end else begin
                mdiv2 <= mdiv2 + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard for dut.
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [23:0] snapm;
    bit          pend = 1'b0;
    logic [15:0] cur;
    bit          oe_prev = 1'b0;

    initial begin
        forever begin
            @(negedge clk);
            if (rd_oe && rst_n) begin
                if (!oe_prev) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R7", int'(rd_data), 0);
                    end else begin
                        logic [15:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(rd_data == e, t, int'(rd_data), int'(e));
                    end
                    cur = rd_data;
                end else begin
                    check(rd_data == cur, "R5", int'(rd_data), int'(cur));
                end
            end
            oe_prev = rd_oe;
        end
    end

    task automatic rd1(input bit hi, input int hold, input string tag);
        @(negedge clk);
        rd_sel = 1'b1; word_hi = hi;
        if (hi || !pend) snapm = mcnt;
        pend = hi;
        exp_q.push_back(hi ? {8'h00, snapm[23:16]} : snapm[15:0]);
        tag_q.push_back(tag);
        @(negedge clk);
        check(rd_oe == 1'b1, "R10", int'(rd_oe), 1);
        repeat (hold - 1) @(negedge clk);
        rd_sel = 1'b0;
        @(negedge clk);
        check(rd_oe == 1'b0 && rd_data == 16'h0, "R8", int'(rd_data), 0);
    endtask

    // Direct checks for dut_div.
    logic [5:0] snap2;
    bit         pend2 = 1'b0;

    task automatic rd2(input bit hi, input int hold, input string tag);
        logic [3:0] e;
        @(negedge clk);
        rs2 = 1'b1; wh2 = hi;
        if (hi || !pend2) snap2 = mcnt2;
        pend2 = hi;
        e = hi ? {2'b00, snap2[5:4]} : snap2[3:0];
        repeat (hold) begin
            @(negedge clk);
            check(oe2 && d2 == e, tag, int'(d2), int'(e));
        end
        rs2 = 1'b0;
        @(negedge clk);
        check(!oe2 && d2 == 4'h0, "R8", int'(d2), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_oe == 1'b0 && rd_data == 16'h0, "R1", int'(rd_data), 0);
        check(oe2 == 1'b0 && d2 == 4'h0, "R1", int'(d2), 0);
        rst_n = 1'b1;

        rd1(1'b0, 1, "R1");
        repeat (5) @(negedge clk);
        rd1(1'b0, 3, "R2");
        rd1(1'b0, 4, "R7");
        rd1(1'b0, 1, "R7");

        // R6: the pending low half survives a long gap.
        rd1(1'b1, 2, "R6");
        repeat (10) @(negedge clk);
        rd1(1'b0, 2, "R6");
        // R6: two high reads in a row; the second captures again.
        rd1(1'b1, 1, "R6");
        repeat (3) @(negedge clk);
        rd1(1'b1, 1, "R6");
        rd1(1'b0, 1, "R6");

        // R1: reset clears a pending high capture.
        rd1(1'b1, 1, "R1");
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(rd_oe == 1'b0 && rd_data == 16'h0, "R1", int'(rd_data), 0);
        rst_n = 1'b1; pend = 1'b0; pend2 = 1'b0;
        rd1(1'b0, 1, "R1");

        // R4: prescaled count.
        repeat (4) @(negedge clk);
        rd2(1'b0, 2, "R4");
        repeat (7) @(negedge clk);
        rd2(1'b0, 1, "R4");

        // R9: hold a capture through a wrap, then leave one pending across it.
        while (mcnt2 != 6'd62) @(negedge clk);
        rd2(1'b1, 25, "R9");
        rd2(1'b0, 1, "R9");
        while (mcnt2 != 6'd1) @(negedge clk);
        rd2(1'b0, 1, "R9");
        rd2(1'b1, 1, "R9");

        // R3: high word carries bits above the bus width.
        repeat (70000) @(negedge clk);
        rd1(1'b1, 2, "R3");
        rd1(1'b0, 2, "R3");
        check(snapm[23:16] != 8'h0, "R3", int'(snapm[23:16]), 1);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R10", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule